// File: doc/BRIEF.md
# Prioritized Pending Interrupt Selector

This block keeps one pending bit for each of twelve interrupt sources of a processor core. A source sets its bit with a one-cycle pulse, and a device may withdraw a pending bit with a drop pulse. Whenever the core signals that it can accept an interrupt, the block picks the one enabled source with the highest priority. It then raises a take strobe for one cycle, together with that source's code, for the exception entry sequencer. The critical enable gates the critical external source, and the external enable gates every lower source. Reset and machine check are never masked.

Sources of the pulse kind are consumed when they are taken. The critical external and external inputs are level-like and stay pending until their device withdraws them. The decrementer is consumed only when a configuration input selects that behaviour. A separate request line tells the core that anything at all is pending.

The controller has three states. ST_IDLE means nothing is pending. ST_ARMED means at least one bit is pending. ST_FIRE is the one cycle in which take is high.
- ST_IDLE or ST_ARMED goes to ST_FIRE when accept is high and an eligible source exists.
- Otherwise, ST_IDLE or ST_ARMED goes to ST_ARMED if the next pending set is non-empty, or to ST_IDLE if it is empty.
- ST_FIRE always leaves after one cycle: to ST_ARMED if anything remains pending, or to ST_IDLE if nothing does. No decision is made in ST_FIRE.

Top module: `irq_select`

## Requirements
- R1: During and directly after reset, take is 0, take_code is 0, irq_req is 0 and no source is pending.
- R2: A set pulse on source i makes bit i pending at the next edge, and irq_req is 1 from that edge on.
- R3: Codes and priority, highest first: 0 reset, 1 machine check, 2 critical external, 3 watchdog, 4 critical doorbell, 5 fixed-interval timer, 6 programmable-interval timer, 7 decrementer, 8 external, 9 doorbell, 10 performance monitor, 11 thermal. The eligible source with the lowest code is the one taken.
- R4: Reset (0) and machine check (1) are taken regardless of crit_en and ext_en, and taking either clears its pending bit.
- R5: Critical external (2) is taken only when crit_en is 1, and taking it leaves its bit pending.
- R6: Codes 3 to 11 are taken only when ext_en is 1.
- R7: Taking code 3, 4, 5, 6, 9, 10 or 11 clears that source's pending bit.
- R8: Taking external (8) leaves its bit pending. Taking the decrementer (7) clears its bit only when dec_clr_cfg is 1.
- R9: Each take lasts exactly one cycle and is followed by at least one cycle without take, and only one source is taken per decision.
- R10: irq_req is 0 exactly when no bit is pending, including after the last bit is cleared by a take or a drop.
- R11: A set pulse in the same cycle as a clear of that bit, whether by a take or by a drop, leaves the bit pending.
- R12: No take occurs in a cycle after accept was 0.
- R13: take and take_code change together at a clock edge. take_code keeps its last value between takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 12 | Per-source set pulses, bit index = code |
| src_drop | input | 12 | Per-source withdraw pulses, bit index = code |
| crit_en | input | 1 | Critical enable |
| ext_en | input | 1 | External enable |
| dec_clr_cfg | input | 1 | 1: decrementer is cleared when taken |
| accept | input | 1 | Core can accept an interrupt this cycle |
| take | output | 1 | One-cycle delivery strobe |
| take_code | output | 4 | Code of the delivered source |
| irq_req | output | 1 | Some source is pending |

## Verification
The block has one cycle of latency. Inputs present between two edges show up at the second edge: take and take_code reflect the decision made from the pending bits and enables of the cycle before, and irq_req reflects the pending set after that edge's set, drop and take clears. The bench drives inputs just after an edge and compares all three outputs a short time after the following edge against a behavioural model that applies the same one-cycle rule. Results are therefore checked in the cycle they are due, never earlier or later.

// File: rtl/intsel_pkg.sv
package intsel_pkg;
    localparam int NSRC   = 12;
    localparam int CODE_W = $clog2(NSRC);

    typedef enum logic [CODE_W-1:0] {
        SRC_RESET = 4'd0, SRC_MCHK = 4'd1, SRC_CRIT = 4'd2, SRC_WDOG = 4'd3,
        SRC_CDBL = 4'd4, SRC_FIT = 4'd5, SRC_PIT = 4'd6, SRC_DEC = 4'd7,
        SRC_EXT = 4'd8, SRC_DBL = 4'd9, SRC_PERF = 4'd10, SRC_THERM = 4'd11
    } src_e;

    typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_FIRE} sel_state_e;

    // Gating classes
    localparam logic [NSRC-1:0] UNMASKED  = NSRC'(12'b0000_0000_0011);
    localparam logic [NSRC-1:0] CE_GATED  = NSRC'(12'b0000_0000_0100);
    localparam logic [NSRC-1:0] EE_GATED  = NSRC'(12'b1111_1111_1000);
    // Clear-on-take classes
    localparam logic [NSRC-1:0] STICKY    = NSRC'(12'b0001_0000_0100);
    localparam logic [NSRC-1:0] CFG_CLEAR = NSRC'(12'b0000_1000_0000);
endpackage

// File: rtl/intsel_pend.sv
module intsel_pend
    import intsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] drop_i,
    input  logic [NSRC-1:0] take_clr_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] pend_nxt_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic bit_q;
        logic bit_d;

        assign bit_d = set_i[i] | (bit_q & ~(take_clr_i[i] | drop_i[i]));

        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end

        assign pend_o[i]     = bit_q;
        assign pend_nxt_o[i] = bit_d;

        // R11: a set pulse always survives a same-cycle clear
        assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(set_i[i])) |-> bit_q);
    end
endmodule

// File: rtl/intsel_pick.sv
module intsel_pick
    import intsel_pkg::*;
(
    input  logic [NSRC-1:0]   pend_i,
    input  logic              crit_en,
    input  logic              ext_en,
    input  logic              dec_clr_cfg,
    output logic              any_o,
    output logic [CODE_W-1:0] code_o,
    output logic [NSRC-1:0]   clr_mask_o
);
    logic [NSRC-1:0] allow;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] win;
    logic [NSRC-1:0] clearable;

    assign allow = UNMASKED | (crit_en ? CE_GATED : '0) | (ext_en ? EE_GATED : '0);
    assign elig  = pend_i & allow;
    assign any_o = |elig;
    assign clearable = ~STICKY & (dec_clr_cfg ? '1 : ~CFG_CLEAR);

    // Lowest index has highest priority
    always_comb begin
        win    = '0;
        code_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win    = '0;
                win[i] = 1'b1;
                code_o = CODE_W'(i);
            end
        end
    end

    assign clr_mask_o = win & clearable;
endmodule

// File: rtl/irq_select.sv
module irq_select
    import intsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] src_set,
    input  logic [11:0] src_drop,
    input  logic        crit_en,
    input  logic        ext_en,
    input  logic        dec_clr_cfg,
    input  logic        accept,
    output logic        take,
    output logic [3:0]  take_code,
    output logic        irq_req
);
    sel_state_e        state_q, state_d;
    logic [NSRC-1:0]   pend_q, pend_d, clr_mask, take_clr;
    logic              any_elig, decide;
    logic [CODE_W-1:0] pick_code, code_q;

    intsel_pend u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(src_set), .drop_i(src_drop),
        .take_clr_i(take_clr), .pend_o(pend_q), .pend_nxt_o(pend_d)
    );

    intsel_pick u_pick (
        .pend_i(pend_q), .crit_en(crit_en), .ext_en(ext_en),
        .dec_clr_cfg(dec_clr_cfg), .any_o(any_elig), .code_o(pick_code),
        .clr_mask_o(clr_mask)
    );

    assign decide   = (state_q != ST_FIRE) && accept && any_elig;
    assign take_clr = decide ? clr_mask : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ARMED: begin
                if (decide)       state_d = ST_FIRE;
                else if (|pend_d) state_d = ST_ARMED;
                else              state_d = ST_IDLE;
            end
            ST_FIRE: state_d = (|pend_d) ? ST_ARMED : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= '0;
        else if (decide) code_q <= pick_code;
    end

    assign take      = (state_q == ST_FIRE);
    assign take_code = code_q;
    assign irq_req   = |pend_q;

    assert_single_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
    assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(accept));
    assert_crit_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_code == SRC_CRIT) |-> $past(crit_en));
    assert_crit_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_code == SRC_CRIT && !$past(src_drop[SRC_CRIT])) |-> pend_q[SRC_CRIT]);
    assert_ee_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_code >= SRC_WDOG) |-> $past(ext_en));
    assert_reset_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_code == SRC_RESET && !$past(src_set[SRC_RESET])) |-> !pend_q[SRC_RESET]);
endmodule

// File: tb/irq_select_test.sv
module irq_select_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src_set = '0, src_drop = '0;
    logic        crit_en = 1'b0, ext_en = 1'b0, dec_clr_cfg = 1'b0, accept = 1'b0;
    logic        take, irq_req;
    logic [3:0]  take_code;

    int checks = 0, failures = 0, cyc = 0;

    irq_select uut (.*);

    always #5 clk = ~clk;

    // Behavioural reference model
    bit m_pend[12];
    bit m_take;
    int m_code;

    function automatic bit allowed(int i);
        if (i < 2) return 1'b1;
        if (i == 2) return crit_en;
        return ext_en;
    endfunction

    function automatic bit consumed(int i);
        if (i == 2 || i == 8) return 1'b0;
        if (i == 7) return dec_clr_cfg;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        bit nxt[12];
        int win;
        win = -1;
        if (!rst_n) begin
            foreach (m_pend[i]) m_pend[i] = 1'b0;
            m_take = 1'b0;
            m_code = 0;
        end else begin
            if (!m_take && accept)
                for (int i = 11; i >= 0; i--)
                    if (m_pend[i] && allowed(i)) win = i;
            foreach (m_pend[i]) begin
                nxt[i] = m_pend[i];
                if (src_drop[i]) nxt[i] = 1'b0;
                if (i == win && consumed(i)) nxt[i] = 1'b0;
                if (src_set[i]) nxt[i] = 1'b1;
            end
            m_pend = nxt;
            m_take = (win >= 0);
            if (win >= 0) m_code = win;
        end
    end

    function automatic bit m_any();
        foreach (m_pend[i]) if (m_pend[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(string tag);
        @(posedge clk);
        #2;
        checks++;
        if (take !== m_take || take_code !== 4'(m_code) || irq_req !== m_any()) begin
            failures++;
            $display("FAIL %s: take=%0b code=%0d req=%0b expected take=%0b code=%0d req=%0b",
                     tag, take, take_code, irq_req, m_take, m_code, m_any());
        end
        src_set  = '0;
        src_drop = '0;
    endtask

    task automatic pulse(int i);
        src_set[i] = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        step("R1");
        step("R1");
        rst_n = 1'b1;
        step("R1");
        // R2 / R6: external pending but masked by ext_en
        accept = 1'b1;
        pulse(8);
        step("R2");
        step("R6");
        step("R6");
        ext_en = 1'b1;
        step("R6");
        step("R8");             // external stays pending and is taken again
        step("R9");
        step("R8");
        src_drop[8] = 1'b1;
        step("R10");
        step("R10");
        // R3: several sources, accept held low then released
        accept = 1'b0;
        pulse(11); pulse(6); pulse(5); pulse(9); pulse(3);
        step("R12");
        step("R12");
        accept = 1'b1;
        for (int k = 0; k < 12; k++) step("R3");
        // R4: reset and machine check with both enables low
        ext_en = 1'b0;
        pulse(1); pulse(0); pulse(4);
        for (int k = 0; k < 6; k++) step("R4");
        // R5: critical external
        pulse(2);
        step("R5");
        step("R5");
        crit_en = 1'b1;
        for (int k = 0; k < 4; k++) step("R5");
        src_drop[2] = 1'b1;
        step("R5");
        // R7: the consumed class, with ext_en high
        ext_en = 1'b1;
        pulse(4); pulse(10);
        for (int k = 0; k < 6; k++) step("R7");
        // R8: decrementer sticky then consumed
        dec_clr_cfg = 1'b0;
        pulse(7);
        for (int k = 0; k < 4; k++) step("R8");
        dec_clr_cfg = 1'b1;
        for (int k = 0; k < 4; k++) step("R8");
        // R11: set on the cycle the watchdog is taken
        pulse(3);
        step("R11");
        pulse(3);
        step("R11");
        for (int k = 0; k < 4; k++) step("R11");
        pulse(9); src_drop[9] = 1'b0;
        step("R11");
        pulse(9); src_drop[9] = 1'b1;
        step("R11");
        step("R11");
        // R13: mixed random traffic
        for (int k = 0; k < 400; k++) begin
            src_set     = 12'($urandom) & 12'($urandom);
            src_drop    = 12'($urandom) & 12'($urandom) & 12'($urandom);
            crit_en     = 1'($urandom);
            ext_en      = 1'($urandom);
            dec_clr_cfg = 1'($urandom);
            accept      = ($urandom % 4) != 0;
            step("R13");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule